// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block steps a micro-program counter through an internal control store. Every stored word drives one datapath strobe per bit on `ctl_sig`, together with a branch-enable bit, a 2-bit condition selector and a jump target that the sequencer itself consumes. A shared three-word fetch routine sits at address 0. Its last word captures the instruction bus into an instruction register and sends the micro-PC to the entry of the routine that belongs to the opcode in bits [7:6]. Each routine ends with a word whose done bit sends the micro-PC back to fetch.

The next micro-PC comes from one of five named sources, chosen in fixed priority. HOLD applies when a word that waits on memory sees `mem_done` low. HOME applies when the done bit is set. ENTRY applies when the word loads the instruction register. JUMP applies when the word has branch enable set and its selected condition is true. INC applies in every other case. The store is filled by a function of the address at elaboration. Four routines are provided: a register-indirect add (seven words including fetch), a branch on negative flag, a branch on external request and an unconditional jump.

Top module: `useq_ctrl`

## Requirements
- R1: An active-low asynchronous `rst_n` clears `upc_o` and `ir_q` to 0. At address 0, `ctl_sig` equals 0x0070D, the first fetch word.
- R2: When no other rule applies, `upc_o` rises by one on each clock. Fetch visits 0, 1, 2 in order.
- R3: When the current word has wait_mem (bit 16) set and `mem_done` is low, `upc_o` and `ctl_sig` hold. The stall takes priority over every other rule. Word 1 (0x10882) and word 4 (0x11080) wait.
- R4: A word with ir_ld (bit 6) set, which is word 2 (0x00050), captures `instr_in` into `ir_q`. It also loads `upc_o` with the entry address for `instr_in[7:6]`: 0→3, 1→7, 2→10, 3→13.
- R5: A word with done (bit 17) set, when not stalled, returns `upc_o` to 0 on the next clock.
- R6: Bit assignment of `ctl_sig`, from 0 to 17: pc_drv, pc_ld, mar_ld, mem_rd, mdr_drv, mdr_ld_ext, ir_ld, y_ld, sel_const, alu_add, z_ld, z_drv, ra_drv, ra_ld, rb_drv, b_ld, wait_mem, done.
- R7: Opcode 0 runs words 3, 4, 5 and 6, seven words counting fetch. Word 6 is 0x22800 (z_drv, ra_ld, done).
- R8: Word 7 branches to 9 (0x20002) when `cc_n` is 1. Otherwise it falls through to 8 (0x20000).
- R9: Word 10 branches to 12 (0x20020) when `ext_req` is 1. Otherwise it falls through to 11 (0x20000).
- R10: Word 13 jumps to 15 (0x24000) whatever the flags are, so word 14 is never reached.
- R11: `cc_n`, `cc_z` and `ext_req` have no effect on words whose branch enable is clear. The opcode-0 trace is unchanged with all of them high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_in | input | IW (8) | Instruction bus, captured by the ir_ld word |
| cc_n | input | 1 | Negative condition flag |
| cc_z | input | 1 | Zero condition flag |
| ext_req | input | 1 | External input that can be tested by branch words |
| mem_done | input | 1 | Memory-complete handshake that ends a wait_mem stall |
| ctl_sig | output | 18 | Datapath strobes of the current control word |
| upc_o | output | AW (5) | Current micro-program counter |
| ir_q | output | IW (8) | Instruction register |

## Verification
The bench holds `mem_done` low on both waiting words. A sequencer that let the stall lose to INC would walk off word 1 or word 4 early, and the held strobes would change. Each conditional branch is driven both ways. A swapped condition selector, or a branch evaluated on non-branch words, shows up as a wrong address after words 7 and 10, or as a bent add trace when the flags are high. The bench also checks that the entry map gives a distinct address for every opcode, that the done word returns to 0 rather than incrementing, and that a reset in the middle of a routine clears both the micro-PC and the instruction register at once.

// File: rtl/useq_pkg.sv
package useq_pkg;
    localparam int NSIG = 18;

    // control-word strobe positions
    localparam int B_PC_DRV  = 0;
    localparam int B_PC_LD   = 1;
    localparam int B_MAR_LD  = 2;
    localparam int B_MEM_RD  = 3;
    localparam int B_MDR_DRV = 4;
    localparam int B_MDR_EXT = 5;
    localparam int B_IR_LD   = 6;
    localparam int B_Y_LD    = 7;
    localparam int B_SEL_C   = 8;
    localparam int B_ADD     = 9;
    localparam int B_Z_LD    = 10;
    localparam int B_Z_DRV   = 11;
    localparam int B_RA_DRV  = 12;
    localparam int B_RA_LD   = 13;
    localparam int B_RB_DRV  = 14;
    localparam int B_B_LD    = 15;
    localparam int B_WAIT    = 16;
    localparam int B_DONE    = 17;

    typedef enum logic [1:0] {
        C_ALWAYS = 2'd0,
        C_NEG    = 2'd1,
        C_ZERO   = 2'd2,
        C_EXT    = 2'd3
    } cond_e;

    typedef enum logic [2:0] {
        SRC_INC,
        SRC_HOLD,
        SRC_HOME,
        SRC_ENTRY,
        SRC_JUMP
    } src_e;
endpackage

// File: rtl/useq_store.sv
module useq_store
    import useq_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0]   addr,
    output logic [NSIG-1:0] sig,
    output logic            br_en,
    output logic [1:0]      csel,
    output logic [AW-1:0]   tgt
);
    localparam int DEPTH = 1 << AW;
    localparam int CW    = NSIG + 1 + 2 + AW;

    function automatic logic [CW-1:0] word_of(input int a);
        logic [NSIG-1:0] s;
        logic            b;
        logic [1:0]      c;
        logic [AW-1:0]   t;
        s = '0;
        b = 1'b0;
        c = C_ALWAYS;
        t = '0;
        case (a)
            0: begin
                s[B_PC_DRV] = 1'b1; s[B_MAR_LD] = 1'b1; s[B_MEM_RD] = 1'b1;
                s[B_SEL_C] = 1'b1;  s[B_ADD] = 1'b1;    s[B_Z_LD] = 1'b1;
            end
            1: begin
                s[B_Z_DRV] = 1'b1; s[B_PC_LD] = 1'b1; s[B_Y_LD] = 1'b1; s[B_WAIT] = 1'b1;
            end
            2: begin
                s[B_MDR_DRV] = 1'b1; s[B_IR_LD] = 1'b1;
            end
            3: begin
                s[B_RB_DRV] = 1'b1; s[B_MAR_LD] = 1'b1; s[B_MEM_RD] = 1'b1;
            end
            4: begin
                s[B_RA_DRV] = 1'b1; s[B_Y_LD] = 1'b1; s[B_WAIT] = 1'b1;
            end
            5: begin
                s[B_MDR_DRV] = 1'b1; s[B_ADD] = 1'b1; s[B_Z_LD] = 1'b1;
            end
            6: begin
                s[B_Z_DRV] = 1'b1; s[B_RA_LD] = 1'b1; s[B_DONE] = 1'b1;
            end
            7: begin
                b = 1'b1; c = C_NEG; t = AW'(9);
            end
            9: begin
                s[B_PC_LD] = 1'b1; s[B_DONE] = 1'b1;
            end
            10: begin
                b = 1'b1; c = C_EXT; t = AW'(12);
            end
            12: begin
                s[B_MDR_EXT] = 1'b1; s[B_DONE] = 1'b1;
            end
            13: begin
                b = 1'b1; c = C_ALWAYS; t = AW'(15);
            end
            14: begin
                s[B_B_LD] = 1'b1; s[B_DONE] = 1'b1;
            end
            15: begin
                s[B_RB_DRV] = 1'b1; s[B_DONE] = 1'b1;
            end
            default: s[B_DONE] = 1'b1;
        endcase
        return {t, c, b, s};
    endfunction

    logic [CW-1:0] rom [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_word
        assign rom[a] = word_of(a);
    end

    assign {tgt, csel, br_en, sig} = rom[addr];
endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
#(
    parameter int AW  = 5,
    parameter int OPW = 2
) (
    input  logic [AW-1:0]  upc,
    input  logic           w_wait,
    input  logic           w_done,
    input  logic           w_irld,
    input  logic           br_en,
    input  logic [1:0]     csel,
    input  logic [AW-1:0]  tgt,
    input  logic [OPW-1:0] opcode,
    input  logic           cc_n,
    input  logic           cc_z,
    input  logic           ext_req,
    input  logic           mem_done,
    output src_e           src,
    output logic [AW-1:0]  nxt
);
    function automatic logic [AW-1:0] entry_of(input logic [OPW-1:0] op);
        case (int'(op))
            0:       return AW'(3);
            1:       return AW'(7);
            2:       return AW'(10);
            3:       return AW'(13);
            default: return '0;
        endcase
    endfunction

    logic cond_ok;

    always_comb begin
        unique case (cond_e'(csel))
            C_ALWAYS: cond_ok = 1'b1;
            C_NEG:    cond_ok = cc_n;
            C_ZERO:   cond_ok = cc_z;
            C_EXT:    cond_ok = ext_req;
        endcase
    end

    always_comb begin
        if (w_wait && !mem_done)  src = SRC_HOLD;
        else if (w_done)          src = SRC_HOME;
        else if (w_irld)          src = SRC_ENTRY;
        else if (br_en && cond_ok) src = SRC_JUMP;
        else                      src = SRC_INC;
    end

    always_comb begin
        unique case (src)
            SRC_HOLD:  nxt = upc;
            SRC_HOME:  nxt = '0;
            SRC_ENTRY: nxt = entry_of(opcode);
            SRC_JUMP:  nxt = tgt;
            SRC_INC:   nxt = upc + AW'(1);
            default:   nxt = upc;
        endcase
    end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int AW  = 5,
    parameter int IW  = 8,
    parameter int OPW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   instr_in,
    input  logic            cc_n,
    input  logic            cc_z,
    input  logic            ext_req,
    input  logic            mem_done,
    output logic [NSIG-1:0] ctl_sig,
    output logic [AW-1:0]   upc_o,
    output logic [IW-1:0]   ir_q
);
    logic [AW-1:0]  upc_q;
    logic [AW-1:0]  upc_nxt;
    logic           br_en;
    logic [1:0]     csel;
    logic [AW-1:0]  tgt;
    src_e           src;

    useq_store #(.AW(AW)) u_store (
        .addr  (upc_q),
        .sig   (ctl_sig),
        .br_en (br_en),
        .csel  (csel),
        .tgt   (tgt)
    );

    useq_next #(.AW(AW), .OPW(OPW)) u_next (
        .upc      (upc_q),
        .w_wait   (ctl_sig[B_WAIT]),
        .w_done   (ctl_sig[B_DONE]),
        .w_irld   (ctl_sig[B_IR_LD]),
        .br_en    (br_en),
        .csel     (csel),
        .tgt      (tgt),
        .opcode   (instr_in[IW-1 -: OPW]),
        .cc_n     (cc_n),
        .cc_z     (cc_z),
        .ext_req  (ext_req),
        .mem_done (mem_done),
        .src      (src),
        .nxt      (upc_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upc_q <= '0;
            ir_q  <= '0;
        end else begin
            upc_q <= upc_nxt;
            if (src == SRC_ENTRY) ir_q <= instr_in;
        end
    end

    always_comb upc_o = upc_q;
endmodule

// File: rtl/useq_chk.sv
module useq_chk
    import useq_pkg::*;
#(
    parameter int AW = 5,
    parameter int IW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [IW-1:0]   instr_in,
    input logic            mem_done,
    input logic [NSIG-1:0] ctl_sig,
    input logic [AW-1:0]   upc_o,
    input logic [IW-1:0]   ir_q
);
    logic [AW-1:0] exp_entry;
    logic          stall;

    assign stall = ctl_sig[B_WAIT] && !mem_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) exp_entry <= '0;
        else begin
            case (instr_in[IW-1 -: 2])
                2'd0: exp_entry <= AW'(3);
                2'd1: exp_entry <= AW'(7);
                2'd2: exp_entry <= AW'(10);
                default: exp_entry <= AW'(13);
            endcase
        end
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(upc_o));

    p_home_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_sig[B_DONE] && !stall) |=> (upc_o == '0));

    p_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_sig[B_IR_LD] && !stall) |=> (upc_o == exp_entry));

    p_irlatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_sig[B_IR_LD] && !stall) |=> (ir_q == $past(instr_in)));

    p_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> (upc_o != $past(upc_o)));
endmodule

bind useq_ctrl useq_chk #(.AW(AW), .IW(IW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .instr_in (instr_in),
    .mem_done (mem_done),
    .ctl_sig  (ctl_sig),
    .upc_o    (upc_o),
    .ir_q     (ir_q)
);

// File: tb/sim_useq_ctrl.sv
`timescale 1ns/1ps
module sim_useq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  instr_in = '0;
    logic        cc_n = 1'b0;
    logic        cc_z = 1'b0;
    logic        ext_req = 1'b0;
    logic        mem_done = 1'b1;
    logic [17:0] ctl_sig;
    logic [4:0]  upc_o;
    logic [7:0]  ir_q;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    useq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .instr_in(instr_in), .cc_n(cc_n),
        .cc_z(cc_z), .ext_req(ext_req), .mem_done(mem_done),
        .ctl_sig(ctl_sig), .upc_o(upc_o), .ir_q(ir_q)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic fetch(input logic [7:0] ins, input int entry);
        chk("R1 fetch start", upc_o, 0);
        step();
        chk("R2 fetch inc", upc_o, 1);
        instr_in = ins;
        step();
        chk("R2 fetch word2", upc_o, 2);
        step();
        chk("R4 entry", upc_o, entry);
        chk("R4 ir latch", ir_q, ins);
    endtask

    task automatic t_reset();
        chk("R1 upc reset", upc_o, 0);
        chk("R1 ctl at 0", ctl_sig, 'h0070D);
        chk("R1 ir reset", ir_q, 0);
    endtask

    task automatic t_add_flags_high();
        cc_n = 1; cc_z = 1; ext_req = 1;
        fetch(8'h2A, 3);
        chk("R6 ctl word3", ctl_sig, 'h0400C);
        step(); chk("R11 add w4", upc_o, 4);
        step(); chk("R11 add w5", upc_o, 5);
        step(); chk("R7 add w6", upc_o, 6);
        chk("R7 ctl w6", ctl_sig, 'h22800);
        step(); chk("R5 home", upc_o, 0);
        cc_n = 0; cc_z = 0; ext_req = 0;
    endtask

    task automatic t_stall();
        mem_done = 0;
        step(); chk("R3 reach w1", upc_o, 1);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R3 hold w1", upc_o, 1);
            chk("R3 ctl held w1", ctl_sig, 'h10882);
        end
        mem_done = 1;
        instr_in = 8'h15;
        step(); chk("R3 release w1", upc_o, 2);
        step(); chk("R4 entry op0", upc_o, 3);
        mem_done = 0;
        step(); chk("R2 to w4", upc_o, 4);
        step(); chk("R3 hold w4", upc_o, 4);
        chk("R3 ctl held w4", ctl_sig, 'h11080);
        mem_done = 1;
        step(); chk("R3 release w4", upc_o, 5);
        step(); step(); chk("R5 home after stall", upc_o, 0);
    endtask

    task automatic t_neg(input logic n, input int dst, input int ctl);
        cc_n = n;
        fetch(8'h40, 7);
        step();
        chk("R8 neg branch", upc_o, dst);
        chk("R8 neg ctl", ctl_sig, ctl);
        step(); chk("R5 home neg", upc_o, 0);
        cc_n = 0;
    endtask

    task automatic t_ext(input logic e, input int dst, input int ctl);
        ext_req = e;
        fetch(8'h80, 10);
        step();
        chk("R9 ext branch", upc_o, dst);
        chk("R9 ext ctl", ctl_sig, ctl);
        step(); chk("R5 home ext", upc_o, 0);
        ext_req = 0;
    endtask

    task automatic t_uncond();
        fetch(8'hC0, 13);
        step();
        chk("R10 jump", upc_o, 15);
        chk("R10 jump ctl", ctl_sig, 'h24000);
        step(); chk("R5 home jump", upc_o, 0);
    endtask

    task automatic t_midreset();
        fetch(8'h3F, 3);
        step(); chk("R2 pre-reset", upc_o, 4);
        rst_n = 0;
        #1;
        chk("R1 async upc", upc_o, 0);
        chk("R1 async ir", ir_q, 0);
        step();
        rst_n = 1;
        step(); chk("R1 restart", upc_o, 1);
        step(); step(); step(); step(); step(); step();
        chk("R5 back to 0", upc_o, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1;
        t_add_flags_high();
        t_stall();
        t_neg(1'b1, 9, 'h20002);
        t_neg(1'b0, 8, 'h20000);
        t_ext(1'b1, 12, 'h20020);
        t_ext(1'b0, 11, 'h20000);
        cc_n = 1; ext_req = 1;
        t_uncond();
        cc_n = 0; ext_req = 0;
        t_uncond();
        t_midreset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule